// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

The block places digital peripheral signals on forty general-purpose pins, grouped as five 8-bit ports. Each peripheral group has an enable bit in one of two 8-bit configuration words, and a single global enable switches the whole crossbar on or off. The pins of the first four ports each have a skip bit. A skipped pin is kept back for analog use, plain GPIO or functions that bypass the crossbar. The fifth port has no skip bits, so its pins are always candidates.

Two peripherals have fixed pins: the serial port takes pins 4 and 5 and the CAN controller takes pins 6 and 7. Every other enabled signal is packed in a fixed priority order onto the lowest-numbered pin that is neither skipped nor already claimed. For each pin the block outputs a select code, an output value and an output enable, and it returns each pin's input to the signal that owns the pin. Any pin left unassigned behaves as GPIO, driven from a latch value and an output enable supplied for each pin. Signals that find no pin are dropped, and a status bit reports the loss.

The configuration and skip inputs are sampled into registers on every clock. The placement is worked out combinationally from those registers.

Top module: `pin_xbar`

## Requirements
- R1: While reset is asserted, and on any cycle whose registered global enable `xbarEn` is 0, every pin select code is 0, every `pinOe` bit is 0, `pinOut` is 0 and `overflow` is 0.
- R2: The configuration and skip inputs take effect on the select codes and on `overflow` only after the next rising clock edge. A change made between edges leaves the outputs unchanged until that edge.
- R3: A pin p < 32 whose `skipMask[p]` is 1 never carries a nonzero select code.
- R4: When `cfgPeriA[0]` is set, signal code 1 (serial TX) sits on pin 4 and code 2 (serial RX) sits on pin 5, each only if its pin is not skipped. When the enable is clear, pins 4 and 5 are free for packing.
- R5: When `cfgPeriA[3]` is set, code 9 (CAN TX) sits on pin 6 and code 10 (CAN RX) sits on pin 7, each only if its pin is not skipped.
- R6: Every other enabled signal gets the lowest free pin, in ascending code order. The codes and their enables are: SPI 3–6 (`cfgPeriA[1]`), SMBus 7–8 (`cfgPeriA[2]`), LIN 11–12 (`cfgPeriA[4]`), comparator outputs 13, 14, 15 (`cfgPeriA[5]`, `[6]`, `[7]`) and 16 (`cfgPeriB[0]`), system clock 17 (`cfgPeriB[1]`), counter clock input 24 (`cfgPeriB[5]`), timer inputs 25 and 26 (`cfgPeriB[6]`, `[7]`). Code 0 means GPIO.
- R7: The field `cfgPeriB[4:2]` gives the number n of capture/compare channels, which take codes 18 up to 17+n. A value of 7 is treated as 6.
- R8: Pins 32–39 have no skip bit and are always eligible for placement.
- R9: `overflow` is 1 exactly when some enabled signal gets no pin, either because free pins ran out or because its fixed pin is skipped. A dropped signal takes no pin, and the placement of the other signals does not change.
- R10: A pin with code c > 0 drives `periOut[c-1]` with enable `periOe[c-1]`. A pin with code 0 drives `gpioOut[p]` with enable `gpioOe[p]`, provided the crossbar is on.
- R11: `periIn[c-1]` equals `pinIn` of the pin that carries code c. It is 0 for any signal that has no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPeriA | input | 8 | Enable bits for the first peripheral group |
| cfgPeriB | input | 8 | Enable bits and capture/compare channel count for the second group |
| xbarEn | input | 1 | Global crossbar enable |
| skipMask | input | 32 | Skip bit for each pin of ports 0–3 |
| periOut | input | 26 | Output value of each peripheral signal |
| periOe | input | 26 | Output enable of each peripheral signal |
| periIn | output | 26 | Input returned to each peripheral signal |
| gpioOut | input | 40 | GPIO latch value for each pin |
| gpioOe | input | 40 | GPIO output enable for each pin |
| pinIn | input | 40 | Value read from each pin |
| pinOut | output | 40 | Value driven on each pin |
| pinOe | output | 40 | Output enable for each pin |
| pinSel | output | 200 | 5-bit select code for each pin, pin p at bits 5p+4..5p |
| overflow | output | 1 | Some enabled signal could not be placed |

## Verification
The assertions check the following on every cycle: the idle state when the crossbar is off, the rule that skipped pins are never claimed, the two fixed-pin peripherals, the range of select codes, and the zero input seen by any unplaced signal. Only the bench's scenarios can show the exact packing order, the clamp on the channel count, placement on the fifth port when all lower pins are skipped, the detection of a dropped signal, and the one-cycle delay from a configuration change to the outputs. For these, the bench compares each cycle against a pin-by-pin placement model, using both directed and randomized enable and skip settings.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;

  // signal set and select code width
  localparam int NSIG  = 26;
  localparam int SEL_W = $clog2(NSIG + 1);

  // signal indices; select code = index + 1
  localparam int SIG_UART_TX = 0;
  localparam int SIG_UART_RX = 1;
  localparam int SIG_SPI0    = 2;
  localparam int SIG_SMB0    = 6;
  localparam int SIG_CAN_TX  = 8;
  localparam int SIG_CAN_RX  = 9;
  localparam int SIG_LIN0    = 10;
  localparam int SIG_CMP0    = 12;
  localparam int SIG_CMP0A   = 13;
  localparam int SIG_CMP1    = 14;
  localparam int SIG_CMP1A   = 15;
  localparam int SIG_SYSCLK  = 16;
  localparam int SIG_CEX0    = 17;
  localparam int SIG_EXTCLK  = 23;
  localparam int SIG_TMR0    = 24;
  localparam int SIG_TMR1    = 25;

  localparam int SPI_N = 4;
  localparam int SMB_N = 2;
  localparam int LIN_N = 2;
  localparam int CEX_N = 6;
  localparam int PCA_FIELD_W = 3;

  // enable bit positions, first group word
  localparam int EN_UART  = 0;
  localparam int EN_SPI   = 1;
  localparam int EN_SMB   = 2;
  localparam int EN_CAN   = 3;
  localparam int EN_LIN   = 4;
  localparam int EN_CMP0  = 5;
  localparam int EN_CMP0A = 6;
  localparam int EN_CMP1  = 7;
  // enable bit positions, second group word
  localparam int EN_CMP1A  = 0;
  localparam int EN_SYSCLK = 1;
  localparam int PCA_LSB   = 2;
  localparam int EN_EXTCLK = 5;
  localparam int EN_TMR0   = 6;
  localparam int EN_TMR1   = 7;

  // signals that have a fixed pin and never join the packing
  localparam logic [NSIG-1:0] FIXED_SIGS =
      (NSIG'(1) << SIG_UART_TX) | (NSIG'(1) << SIG_UART_RX) |
      (NSIG'(1) << SIG_CAN_TX)  | (NSIG'(1) << SIG_CAN_RX);

  // strobes from the control to the placement logic
  typedef struct packed {
    logic            xbarOn;
    logic [NSIG-1:0] sigReq;
  } xbarStrobe_t;

endpackage

// File: rtl/pin_xbar_ctrl.sv
module pin_xbar_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int SKIP_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           cfgPeriA,
  input  logic [7:0]           cfgPeriB,
  input  logic                 xbarEn,
  input  logic [SKIP_PINS-1:0] skipMask,
  output xbarStrobe_t          strobe,
  output logic [SKIP_PINS-1:0] skipQ
);

  logic [7:0]             periAQ;
  logic [7:0]             periBQ;
  logic                   enQ;
  logic [PCA_FIELD_W-1:0] pcaRaw;
  logic [PCA_FIELD_W-1:0] pcaN;
  logic [NSIG-1:0]        req;

  // configuration registers, sampled every cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periAQ <= '0;
      periBQ <= '0;
      enQ    <= 1'b0;
      skipQ  <= '0;
    end else begin
      periAQ <= cfgPeriA;
      periBQ <= cfgPeriB;
      enQ    <= xbarEn;
      skipQ  <= skipMask;
    end
  end

  assign pcaRaw = periBQ[PCA_LSB +: PCA_FIELD_W];
  assign pcaN   = (pcaRaw > PCA_FIELD_W'(CEX_N)) ? PCA_FIELD_W'(CEX_N) : pcaRaw;

  // turn the enable bits into one request per signal
  always_comb begin
    req = '0;
    if (enQ) begin
      req[SIG_UART_TX]         = periAQ[EN_UART];
      req[SIG_UART_RX]         = periAQ[EN_UART];
      req[SIG_SPI0 +: SPI_N]   = {SPI_N{periAQ[EN_SPI]}};
      req[SIG_SMB0 +: SMB_N]   = {SMB_N{periAQ[EN_SMB]}};
      req[SIG_CAN_TX]          = periAQ[EN_CAN];
      req[SIG_CAN_RX]          = periAQ[EN_CAN];
      req[SIG_LIN0 +: LIN_N]   = {LIN_N{periAQ[EN_LIN]}};
      req[SIG_CMP0]            = periAQ[EN_CMP0];
      req[SIG_CMP0A]           = periAQ[EN_CMP0A];
      req[SIG_CMP1]            = periAQ[EN_CMP1];
      req[SIG_CMP1A]           = periBQ[EN_CMP1A];
      req[SIG_SYSCLK]          = periBQ[EN_SYSCLK];
      for (int i = 0; i < CEX_N; i++) begin
        req[SIG_CEX0 + i] = (PCA_FIELD_W'(i) < pcaN);
      end
      req[SIG_EXTCLK]          = periBQ[EN_EXTCLK];
      req[SIG_TMR0]            = periBQ[EN_TMR0];
      req[SIG_TMR1]            = periBQ[EN_TMR1];
    end
  end

  assign strobe.xbarOn = enQ;
  assign strobe.sigReq = req;

endmodule

// File: rtl/pin_xbar_packer.sv
module pin_xbar_packer
  import pin_xbar_pkg::*;
#(
  parameter int NPINS     = 40,
  parameter int SKIP_PINS = 32,
  parameter int UART_PIN  = 4,
  parameter int CAN_PIN   = 6
) (
  input  xbarStrobe_t                    strobe,
  input  logic [SKIP_PINS-1:0]           skipQ,
  output logic [NPINS-1:0][SEL_W-1:0]    pinSel,
  output logic                           overflow
);

  localparam int RANK_W      = $clog2(NPINS + 1);
  localparam int UART_RX_PIN = UART_PIN + 1;
  localparam int CAN_RX_PIN  = CAN_PIN + 1;

  logic [NPINS-1:0]              skipped;
  logic [NPINS-1:0]              fixedClaim;
  logic [NPINS-1:0][SEL_W-1:0]   fixedCode;
  logic                          fixedMiss;
  logic [NPINS-1:0]              freePin;
  logic [NPINS-1:0][RANK_W-1:0]  rank;
  logic [RANK_W-1:0]             freeTotal;
  logic [NSIG-1:0]               packReq;
  logic [NSIG-1:0][RANK_W-1:0]   slot;
  logic [RANK_W-1:0]             packTotal;

  // ports above the skip range have no skip bit
  for (genvar p = 0; p < NPINS; p++) begin : g_skip
    if (p < SKIP_PINS) begin : g_has
      assign skipped[p] = skipQ[p];
    end else begin : g_none
      assign skipped[p] = 1'b0;
    end
  end

  // fixed-location signals
  always_comb begin
    fixedClaim = '0;
    fixedCode  = '0;
    fixedMiss  = 1'b0;
    if (strobe.sigReq[SIG_UART_TX]) begin
      if (skipped[UART_PIN]) fixedMiss = 1'b1;
      else begin
        fixedClaim[UART_PIN] = 1'b1;
        fixedCode[UART_PIN]  = SEL_W'(SIG_UART_TX + 1);
      end
    end
    if (strobe.sigReq[SIG_UART_RX]) begin
      if (skipped[UART_RX_PIN]) fixedMiss = 1'b1;
      else begin
        fixedClaim[UART_RX_PIN] = 1'b1;
        fixedCode[UART_RX_PIN]  = SEL_W'(SIG_UART_RX + 1);
      end
    end
    if (strobe.sigReq[SIG_CAN_TX]) begin
      if (skipped[CAN_PIN]) fixedMiss = 1'b1;
      else begin
        fixedClaim[CAN_PIN] = 1'b1;
        fixedCode[CAN_PIN]  = SEL_W'(SIG_CAN_TX + 1);
      end
    end
    if (strobe.sigReq[SIG_CAN_RX]) begin
      if (skipped[CAN_RX_PIN]) fixedMiss = 1'b1;
      else begin
        fixedClaim[CAN_RX_PIN] = 1'b1;
        fixedCode[CAN_RX_PIN]  = SEL_W'(SIG_CAN_RX + 1);
      end
    end
  end

  assign freePin = ~skipped & ~fixedClaim;
  assign packReq = strobe.sigReq & ~FIXED_SIGS;

  // rank of each free pin among the free pins
  always_comb begin
    logic [RANK_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NPINS; p++) begin
      rank[p] = acc;
      if (freePin[p]) acc = acc + RANK_W'(1);
    end
    freeTotal = acc;
  end

  // slot of each requesting signal in priority order
  always_comb begin
    logic [RANK_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NSIG; k++) begin
      slot[k] = acc;
      if (packReq[k]) acc = acc + RANK_W'(1);
    end
    packTotal = acc;
  end

  // a free pin takes the signal whose slot matches its rank
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pinSel[p] = fixedCode[p];
      if (freePin[p]) begin
        for (int k = 0; k < NSIG; k++) begin
          if (packReq[k] && (slot[k] == rank[p])) pinSel[p] = SEL_W'(k + 1);
        end
      end
    end
  end

  assign overflow = strobe.xbarOn && ((packTotal > freeTotal) || fixedMiss);

endmodule

// File: rtl/pin_xbar_mux.sv
module pin_xbar_mux
  import pin_xbar_pkg::*;
#(
  parameter int NPINS = 40
) (
  input  logic                         xbarOn,
  input  logic [NPINS-1:0][SEL_W-1:0]  pinSel,
  input  logic [NSIG-1:0]              periOut,
  input  logic [NSIG-1:0]              periOe,
  input  logic [NPINS-1:0]             gpioOut,
  input  logic [NPINS-1:0]             gpioOe,
  input  logic [NPINS-1:0]             pinIn,
  output logic [NPINS-1:0]             pinOut,
  output logic [NPINS-1:0]             pinOe,
  output logic [NSIG-1:0]              periIn
);

  // pin side: peripheral, GPIO or idle
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pinOut[p] = 1'b0;
      pinOe[p]  = 1'b0;
      if (xbarOn) begin
        pinOut[p] = gpioOut[p];
        pinOe[p]  = gpioOe[p];
        for (int k = 0; k < NSIG; k++) begin
          if (pinSel[p] == SEL_W'(k + 1)) begin
            pinOut[p] = periOut[k];
            pinOe[p]  = periOe[k];
          end
        end
      end
    end
  end

  // peripheral side: input from the owning pin
  always_comb begin
    for (int k = 0; k < NSIG; k++) begin
      periIn[k] = 1'b0;
      for (int p = 0; p < NPINS; p++) begin
        if (pinSel[p] == SEL_W'(k + 1)) periIn[k] = periIn[k] | pinIn[p];
      end
    end
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int N_PORTS      = 5,
  parameter int PORT_BITS    = 8,
  parameter int N_SKIP_PORTS = 4,
  parameter int UART_PIN     = 4,
  parameter int CAN_PIN      = 6,
  localparam int NPINS       = N_PORTS * PORT_BITS,
  localparam int SKIP_PINS   = N_SKIP_PORTS * PORT_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             cfgPeriA,
  input  logic [7:0]             cfgPeriB,
  input  logic                   xbarEn,
  input  logic [SKIP_PINS-1:0]   skipMask,
  input  logic [NSIG-1:0]        periOut,
  input  logic [NSIG-1:0]        periOe,
  output logic [NSIG-1:0]        periIn,
  input  logic [NPINS-1:0]       gpioOut,
  input  logic [NPINS-1:0]       gpioOe,
  input  logic [NPINS-1:0]       pinIn,
  output logic [NPINS-1:0]       pinOut,
  output logic [NPINS-1:0]       pinOe,
  output logic [NPINS*SEL_W-1:0] pinSel,
  output logic                   overflow
);

  xbarStrobe_t                  strobe;
  logic [SKIP_PINS-1:0]         skipQ;
  logic [NPINS-1:0][SEL_W-1:0]  selArr;

  pin_xbar_ctrl #(.SKIP_PINS(SKIP_PINS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgPeriA (cfgPeriA),
    .cfgPeriB (cfgPeriB),
    .xbarEn   (xbarEn),
    .skipMask (skipMask),
    .strobe   (strobe),
    .skipQ    (skipQ)
  );

  pin_xbar_packer #(
    .NPINS     (NPINS),
    .SKIP_PINS (SKIP_PINS),
    .UART_PIN  (UART_PIN),
    .CAN_PIN   (CAN_PIN)
  ) u_packer (
    .strobe   (strobe),
    .skipQ    (skipQ),
    .pinSel   (selArr),
    .overflow (overflow)
  );

  pin_xbar_mux #(.NPINS(NPINS)) u_mux (
    .xbarOn  (strobe.xbarOn),
    .pinSel  (selArr),
    .periOut (periOut),
    .periOe  (periOe),
    .gpioOut (gpioOut),
    .gpioOe  (gpioOe),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .periIn  (periIn)
  );

  assign pinSel = selArr;

endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NPINS     = 40,
  parameter int SKIP_PINS = 32,
  parameter int UART_PIN  = 4,
  parameter int CAN_PIN   = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [7:0]             cfgPeriA,
  input logic                   xbarEn,
  input logic [SKIP_PINS-1:0]   skipMask,
  input logic [NSIG-1:0]        periIn,
  input logic [NPINS-1:0]       pinOe,
  input logic [NPINS*SEL_W-1:0] pinSel,
  input logic                   overflow
);

  logic [NPINS-1:0] selNz;
  logic [NPINS-1:0] codeOk;
  logic [NSIG-1:0]  placed;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign selNz[p]  = |pinSel[p*SEL_W +: SEL_W];
    assign codeOk[p] = (pinSel[p*SEL_W +: SEL_W] <= SEL_W'(NSIG));
  end

  always_comb begin
    placed = '0;
    for (int k = 0; k < NSIG; k++) begin
      for (int p = 0; p < NPINS; p++) begin
        if (pinSel[p*SEL_W +: SEL_W] == SEL_W'(k + 1)) placed[k] = 1'b1;
      end
    end
  end

  // R1
  xbar_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(xbarEn)) |-> (selNz == '0 && pinOe == '0 && !overflow));

  // R3
  skip_respected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((selNz[SKIP_PINS-1:0] & $past(skipMask)) == '0));

  // R4
  uart_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(xbarEn) && $past(cfgPeriA[EN_UART]) && !$past(skipMask[UART_PIN]))
    |-> (pinSel[UART_PIN*SEL_W +: SEL_W] == SEL_W'(SIG_UART_TX + 1)));

  // R5
  can_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(xbarEn) && $past(cfgPeriA[EN_CAN]) && !$past(skipMask[CAN_PIN]))
    |-> (pinSel[CAN_PIN*SEL_W +: SEL_W] == SEL_W'(SIG_CAN_TX + 1)));

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    &codeOk);

  // R11
  unplaced_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((periIn & ~placed) == '0));

endmodule

bind pin_xbar pin_xbar_chk #(
  .NPINS     (NPINS),
  .SKIP_PINS (SKIP_PINS),
  .UART_PIN  (UART_PIN),
  .CAN_PIN   (CAN_PIN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgPeriA (cfgPeriA),
  .xbarEn   (xbarEn),
  .skipMask (skipMask),
  .periIn   (periIn),
  .pinOe    (pinOe),
  .pinSel   (pinSel),
  .overflow (overflow)
);

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;

  localparam int NP  = 40;
  localparam int NSK = 32;
  localparam int NS  = 26;
  localparam int SW  = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      cfgPeriA = '1;
  logic [7:0]      cfgPeriB = '1;
  logic            xbarEn = 1'b1;
  logic [NSK-1:0]  skipMask = '0;
  logic [NS-1:0]   periOut = '1;
  logic [NS-1:0]   periOe = '1;
  logic [NS-1:0]   periIn;
  logic [NP-1:0]   gpioOut = '1;
  logic [NP-1:0]   gpioOe = '1;
  logic [NP-1:0]   pinIn = '1;
  logic [NP-1:0]   pinOut;
  logic [NP-1:0]   pinOe;
  logic [NP*SW-1:0] pinSel;
  logic            overflow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NP*SW-1:0] sel;
    logic             ovf;
    logic [NP-1:0]    pout;
    logic [NP-1:0]    poe;
    logic [NS-1:0]    pin;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  logic [NP*SW-1:0] lastSel = '0;
  logic             lastOvf = 1'b0;

  always #2 clk = ~clk;

  pin_xbar u_pin_xbar (
    .clk(clk), .rstN(rstN), .cfgPeriA(cfgPeriA), .cfgPeriB(cfgPeriB),
    .xbarEn(xbarEn), .skipMask(skipMask), .periOut(periOut), .periOe(periOe),
    .periIn(periIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinSel(pinSel), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // placement model, walks pins one by one
  function automatic expItem_t refModel(input logic [7:0] a, input logic [7:0] b,
                                        input logic en, input logic [NSK-1:0] sk);
    expItem_t e;
    logic [NS-1:0] rq;
    logic [NP-1:0] taken;
    int code[NP];
    int fixSig[4] = '{0, 1, 8, 9};
    int fixPin[4] = '{4, 5, 6, 7};
    int n;
    rq = '0;
    e.ovf = 1'b0;
    if (en) begin
      if (a[0]) rq[1:0] = 2'b11;     // serial
      if (a[1]) rq[5:2] = 4'hf;      // SPI
      if (a[2]) rq[7:6] = 2'b11;     // SMBus
      if (a[3]) rq[9:8] = 2'b11;     // CAN
      if (a[4]) rq[11:10] = 2'b11;   // LIN
      rq[12] = a[5]; rq[13] = a[6]; rq[14] = a[7];
      rq[15] = b[0]; rq[16] = b[1];
      n = int'(b[4:2]);
      if (n > 6) n = 6;
      for (int i = 0; i < n; i++) rq[17 + i] = 1'b1;
      rq[23] = b[5]; rq[24] = b[6]; rq[25] = b[7];
    end
    for (int p = 0; p < NP; p++) code[p] = 0;
    taken = '0;
    for (int f = 0; f < 4; f++) begin
      if (rq[fixSig[f]]) begin
        if (sk[fixPin[f]]) e.ovf = 1'b1;
        else begin
          code[fixPin[f]] = fixSig[f] + 1;
          taken[fixPin[f]] = 1'b1;
        end
      end
    end
    for (int k = 0; k < NS; k++) begin
      if (rq[k] && k != 0 && k != 1 && k != 8 && k != 9) begin
        bit got = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (!got && !taken[p] && !(p < NSK && sk[p])) begin
            code[p] = k + 1;
            taken[p] = 1'b1;
            got = 1'b1;
          end
        end
        if (!got) e.ovf = 1'b1;
      end
    end
    e.pin = '0;
    for (int p = 0; p < NP; p++) begin
      e.sel[p*SW +: SW] = SW'(code[p]);
      if (!en) begin
        e.pout[p] = 1'b0;
        e.poe[p]  = 1'b0;
      end else if (code[p] == 0) begin
        e.pout[p] = gpioOut[p];
        e.poe[p]  = gpioOe[p];
      end else begin
        e.pout[p] = periOut[code[p] - 1];
        e.poe[p]  = periOe[code[p] - 1];
        e.pin[code[p] - 1] = pinIn[p];
      end
    end
    return e;
  endfunction

  task automatic randPins();
    periOut = NS'($urandom());
    periOe  = NS'($urandom());
    gpioOut = NP'({$urandom(), $urandom()});
    gpioOe  = NP'({$urandom(), $urandom()});
    pinIn   = NP'({$urandom(), $urandom()});
  endtask

  // driver: apply a setting and queue what the next edge must produce
  task automatic applyVec(input logic [7:0] a, input logic [7:0] b, input logic en,
                          input logic [NSK-1:0] sk, input string tag);
    @(negedge clk);
    cfgPeriA = a; cfgPeriB = b; xbarEn = en; skipMask = sk;
    randPins();
    expQ.push_back(refModel(a, b, en, sk));
    tagQ.push_back(tag);
  endtask

  // R2: change between edges must not show before the edge
  task automatic holdCheck(input logic [7:0] a, input logic [7:0] b, input logic en,
                           input logic [NSK-1:0] sk);
    @(negedge clk);
    cfgPeriA = a; cfgPeriB = b; xbarEn = en; skipMask = sk;
    #1;
    check(pinSel == lastSel, "R2", "pinSel before edge", 256'(pinSel), 256'(lastSel));
    check(overflow == lastOvf, "R2", "overflow before edge", 256'(overflow), 256'(lastOvf));
    expQ.push_back(refModel(a, b, en, sk));
    tagQ.push_back("R2");
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(pinSel == e.sel, t, "pinSel (R6)", 256'(pinSel), 256'(e.sel));
        check(overflow == e.ovf, t, "overflow (R9)", 256'(overflow), 256'(e.ovf));
        check(pinOut == e.pout, "R10", "pinOut", 256'(pinOut), 256'(e.pout));
        check(pinOe == e.poe, "R10", "pinOe", 256'(pinOe), 256'(e.poe));
        check(periIn == e.pin, "R11", "periIn", 256'(periIn), 256'(e.pin));
        lastSel = e.sel;
        lastOvf = e.ovf;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: held in reset with everything enabled
    repeat (3) @(negedge clk);
    check(pinSel == '0, "R1", "pinSel in reset", 256'(pinSel), 256'(0));
    check(pinOe == '0, "R1", "pinOe in reset", 256'(pinOe), 256'(0));
    check(overflow == 1'b0, "R1", "overflow in reset", 256'(overflow), 256'(0));
    rstN = 1'b1;

    // R1: crossbar off
    applyVec(8'hff, 8'hff, 1'b0, '0, "R1");
    // R4: serial alone, then with TX pin skipped
    applyVec(8'h01, 8'h00, 1'b1, '0, "R4");
    applyVec(8'h01, 8'h00, 1'b1, 32'h0000_0010, "R4");
    // R4: serial off frees pins 4 and 5
    applyVec(8'h02, 8'h03, 1'b1, 32'h0000_000f, "R4");
    // R5: CAN with SPI packed below
    applyVec(8'h0a, 8'h00, 1'b1, '0, "R5");
    applyVec(8'h08, 8'h00, 1'b1, 32'h0000_0080, "R5");
    // R6: everything except fixed peripherals
    applyVec(8'hf6, 8'hff, 1'b1, '0, "R6");
    applyVec(8'hff, 8'hff, 1'b1, 32'h5555_0000, "R6");
    // R3: scattered skips
    applyVec(8'hff, 8'hff, 1'b1, 32'ha5a5_a5a5, "R3");
    // R7: channel count 3, 6 and 7
    applyVec(8'h00, 8'h0c, 1'b1, '0, "R7");
    applyVec(8'h00, 8'h18, 1'b1, '0, "R7");
    applyVec(8'h00, 8'h1c, 1'b1, '0, "R7");
    // R8: all lower pins skipped, SPI lands on port 4
    applyVec(8'h02, 8'h00, 1'b1, 32'hffff_ffff, "R8");
    // R9: too many signals for port 4 alone
    applyVec(8'hff, 8'hff, 1'b1, 32'hffff_ffff, "R9");
    applyVec(8'h00, 8'h00, 1'b1, 32'hffff_ffff, "R9");
    // R2: late change between edges
    holdCheck(8'hff, 8'h00, 1'b1, '0);
    holdCheck(8'h00, 8'h00, 1'b0, '0);
    // R10 R11 with random settings
    for (int i = 0; i < 150; i++) begin
      applyVec(8'($urandom()), 8'($urandom()), ($urandom() % 8) != 0,
               $urandom() & $urandom(), "R6");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule